// File: doc/BRIEF.md
# Four-Channel Burst DMA Engine

This block moves data between a memory-side beat port and a device-side beat port on behalf of four independent channels. Software programs each channel through a small register bus: a source address, a destination address, a block count in units of 32 bytes, and a control word. The control word carries the channel enable, a hardware-set completion flag, a direction bit and one address-mode field for each side. A single global register holds the master enable for the whole engine.

A channel moves data only when its attached device asks for it. Each grant moves one 32-byte burst as eight back-to-back 32-bit beats. A word read on one port is forwarded in the same cycle to the other port. After each burst the engine writes back the advanced addresses and the reduced count. When the count reaches zero it raises the completion flag and leaves every other control bit as it was.

Top module: `dmaq_engine`

## Requirements
- R1: After reset every channel register and the global register read 0. No beat is issued and no acknowledge is raised.
- R2: The registers of channel c sit at byte address c*16: source at +0x0, destination at +0x4, block count at +0x8 and control at +0xC. The global register sits at 0x40. A written value reads back unchanged. A write to an address with non-zero low two bits has no effect.
- R3: A channel is granted only when all of these hold: control bit 0 (enable) is 1, control bit 1 (done) is 0, its block count is non-zero, global bit 0 (master enable) is 1, and its request input is high. Otherwise it issues no beats and its registers do not change.
- R4: A grant pulses that channel's acknowledge bit for one cycle. The next eight cycles carry one beat each, with the channel number on the device side. No acknowledge is raised while a burst is in progress.
- R5: After each burst, an incrementing address has advanced by 32, a fixed address is unchanged, and the block count has dropped by one.
- R6: When the block count reaches 0, control bit 1 is set and all other control bits are kept, so 0x12C1 becomes 0x12C3. The channel then issues no further beats, even if its count is reloaded.
- R7: Writing the control word with bit 1 clear clears the done flag. Once enabled again, the channel resumes from its current addresses.
- R8: When several channels are eligible in the same cycle, the lowest channel number wins. Arbitration is repeated before every burst.
- R9: Control bit 8 sets the direction. When it is 0, memory is read at the source-side address and the device is written at the destination-side address. When it is 1, the device is read at the source-side address and memory is written at the destination-side address. Read data appears as write data in the same cycle.
- R10: Control bits 13:12 set the source address mode and bits 15:14 set the destination address mode. Value 01 increments by 4 per beat. Any other value keeps the address fixed for every beat. So 0x12C0 is memory-to-device with an incrementing source, 0x43C0 is device-to-memory with an incrementing destination, and 0x22C0 keeps both sides fixed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| dreq | input | 4 | Per-channel device request level |
| dack | output | 4 | One-cycle grant pulse per channel |
| mem_valid | output | 1 | Memory beat active |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Memory beat address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| dev_valid | output | 1 | Device beat active |
| dev_we | output | 1 | Device beat is a write |
| dev_ch | output | 2 | Channel owning the beat |
| dev_addr | output | 32 | Device-side address |
| dev_wdata | output | 32 | Device write data |
| dev_rdata | input | 32 | Device read data, same cycle |

## Verification
Two situations are hard to reach from the ports: two channels becoming eligible in the same cycle, and a channel that is enabled but blocked by a set done flag or a zero count. For the first, the bench fully programs and enables two channels while their requests are held low, then raises both requests in one step. The channel numbers on the beats then show the winner. For the second, the bench reloads a finished channel's count without clearing the done flag, and enables a channel whose count is zero. With the request held high in both cases, the scoreboard must see no beat, and the registers are read back unchanged.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

  localparam int WORD_BYTES  = 4;
  localparam int BURST_BEATS = 8;
  localparam int BEAT_W      = $clog2(BURST_BEATS);

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_RSV_A = 2'b10,
    AM_RSV_B = 2'b11
  } amode_e;

  localparam int CTL_ON   = 0;
  localparam int CTL_DONE = 1;
  localparam int CTL_DIR  = 8;
  localparam int CTL_SRCM = 12;
  localparam int CTL_DSTM = 14;

  // mode of one side of the transfer: dst_side = 1 picks the destination field
  function automatic logic side_incr(input logic [31:0] ctl, input logic dst_side);
    amode_e m;
    m = dst_side ? amode_e'(ctl[CTL_DSTM +: 2]) : amode_e'(ctl[CTL_SRCM +: 2]);
    return (m == AM_INC);
  endfunction

  // address after nbeats words on one side
  function automatic logic [31:0] walk_addr(input logic [31:0] base, input logic incr,
                                            input logic [31:0] nbeats);
    return incr ? base + (nbeats * WORD_BYTES) : base;
  endfunction

  function automatic logic dir_to_mem(input logic [31:0] ctl);
    return ctl[CTL_DIR];
  endfunction

endpackage

// File: rtl/dmaq_chan_regs.sv
module dmaq_chan_regs
  import dmaq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_src,
  input  logic        wr_dst,
  input  logic        wr_cnt,
  input  logic        wr_ctl,
  input  logic [31:0] wdata,
  input  logic        wb_en,
  input  logic [31:0] wb_src,
  input  logic [31:0] wb_dst,
  input  logic [31:0] wb_cnt,
  output logic [31:0] src_q,
  output logic [31:0] dst_q,
  output logic [31:0] cnt_q,
  output logic [31:0] ctl_q
);

  // burst write-back first, a software write in the same cycle wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wb_en) begin
        src_q <= wb_src;
        dst_q <= wb_dst;
        cnt_q <= wb_cnt;
        if (wb_cnt == 32'd0) ctl_q[CTL_DONE] <= 1'b1;
      end
      if (wr_src) src_q <= wdata;
      if (wr_dst) dst_q <= wdata;
      if (wr_cnt) cnt_q <= wdata;
      if (wr_ctl) ctl_q <= wdata;
    end
  end

endmodule

// File: rtl/dmaq_pick.sv
module dmaq_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  // lowest set bit wins
  always_comb begin
    gnt = req & (~req + N'(1));
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end

endmodule

// File: rtl/dmaq_beat_seq.sv
module dmaq_beat_seq
  import dmaq_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] start_idx,
  input  logic [31:0]   start_src,
  input  logic [31:0]   start_dst,
  input  logic [31:0]   start_cnt,
  input  logic [31:0]   start_ctl,
  input  logic [31:0]   mem_rdata,
  input  logic [31:0]   dev_rdata,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] done_idx,
  output logic [31:0]   wb_src,
  output logic [31:0]   wb_dst,
  output logic [31:0]   wb_cnt,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          dev_valid,
  output logic          dev_we,
  output logic [IW-1:0] dev_ch,
  output logic [31:0]   dev_addr,
  output logic [31:0]   dev_wdata
);

  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;
  logic [IW-1:0]     idx_q;
  logic [31:0]       src_l, dst_l, cnt_l;
  logic              src_inc_l, dst_inc_l, to_mem_l;
  logic [31:0]       beat_src, beat_dst;
  logic              last_beat;

  assign last_beat = busy_q && (beat_q == BEAT_W'(BURST_BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      beat_q    <= '0;
      idx_q     <= '0;
      src_l     <= '0;
      dst_l     <= '0;
      cnt_l     <= '0;
      src_inc_l <= 1'b0;
      dst_inc_l <= 1'b0;
      to_mem_l  <= 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q    <= 1'b1;
        beat_q    <= '0;
        idx_q     <= start_idx;
        src_l     <= start_src;
        dst_l     <= start_dst;
        cnt_l     <= start_cnt;
        src_inc_l <= side_incr(start_ctl, 1'b0);
        dst_inc_l <= side_incr(start_ctl, 1'b1);
        to_mem_l  <= dir_to_mem(start_ctl);
      end
    end else begin
      beat_q <= beat_q + BEAT_W'(1);
      if (last_beat) busy_q <= 1'b0;
    end
  end

  assign beat_src = walk_addr(src_l, src_inc_l, 32'(beat_q));
  assign beat_dst = walk_addr(dst_l, dst_inc_l, 32'(beat_q));

  assign busy      = busy_q;
  assign mem_valid = busy_q;
  assign dev_valid = busy_q;
  assign mem_we    = busy_q & to_mem_l;
  assign dev_we    = busy_q & ~to_mem_l;
  assign mem_addr  = to_mem_l ? beat_dst : beat_src;
  assign dev_addr  = to_mem_l ? beat_src : beat_dst;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
  assign dev_ch    = idx_q;

  // burst end event with the values to write back
  assign done     = last_beat;
  assign done_idx = idx_q;
  assign wb_src   = walk_addr(src_l, src_inc_l, 32'(BURST_BEATS));
  assign wb_dst   = walk_addr(dst_l, dst_inc_l, 32'(BURST_BEATS));
  assign wb_cnt   = cnt_l - 32'd1;

endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
  import dmaq_pkg::*;
#(
  parameter  int NUM_CH = 4,
  localparam int BUS_AW = $clog2((NUM_CH + 1) * 16),
  localparam int IW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] dreq,
  output logic [NUM_CH-1:0] dack,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              dev_valid,
  output logic              dev_we,
  output logic [IW-1:0]     dev_ch,
  output logic [31:0]       dev_addr,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata
);

  localparam int BLK_W = BUS_AW - 4;

  logic [BLK_W-1:0]  blk;
  logic [1:0]        slot;
  logic              aligned;
  logic [31:0]       glob_q;
  logic              master_en;
  logic [31:0]       src_a [NUM_CH];
  logic [31:0]       dst_a [NUM_CH];
  logic [31:0]       cnt_a [NUM_CH];
  logic [31:0]       ctl_a [NUM_CH];
  logic [NUM_CH-1:0] te_vec;
  logic [NUM_CH-1:0] armed;
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] gnt;
  logic [IW-1:0]     gnt_idx;
  logic              gnt_any;
  logic              busy;
  logic              done;
  logic [IW-1:0]     done_idx;
  logic [31:0]       wb_src, wb_dst, wb_cnt;

  assign blk     = bus_addr[BUS_AW-1:4];
  assign slot    = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  // global register, bit 0 is the master enable
  always_ff @(posedge clk) begin
    if (!rst_n) glob_q <= '0;
    else if (bus_wr && aligned && blk == BLK_W'(NUM_CH) && slot == 2'd0) glob_q <= bus_wdata;
  end
  assign master_en = glob_q[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_wr && aligned && (blk == BLK_W'(c));
    dmaq_chan_regs u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_src (hit && slot == 2'd0),
      .wr_dst (hit && slot == 2'd1),
      .wr_cnt (hit && slot == 2'd2),
      .wr_ctl (hit && slot == 2'd3),
      .wdata  (bus_wdata),
      .wb_en  (done && done_idx == IW'(c)),
      .wb_src (wb_src),
      .wb_dst (wb_dst),
      .wb_cnt (wb_cnt),
      .src_q  (src_a[c]),
      .dst_q  (dst_a[c]),
      .cnt_q  (cnt_a[c]),
      .ctl_q  (ctl_a[c])
    );
    assign te_vec[c] = ctl_a[c][CTL_DONE];
    assign armed[c]  = ctl_a[c][CTL_ON] && !te_vec[c] && (cnt_a[c] != 32'd0);
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (blk == BLK_W'(c)) begin
          case (slot)
            2'd0:    bus_rdata = src_a[c];
            2'd1:    bus_rdata = dst_a[c];
            2'd2:    bus_rdata = cnt_a[c];
            default: bus_rdata = ctl_a[c];
          endcase
        end
      end
      if (blk == BLK_W'(NUM_CH) && slot == 2'd0) bus_rdata = glob_q;
    end
  end

  assign eligible = armed & dreq & {NUM_CH{master_en}} & {NUM_CH{~busy}};

  dmaq_pick #(.N(NUM_CH), .IW(IW)) u_pick (
    .req (eligible),
    .gnt (gnt),
    .idx (gnt_idx),
    .any (gnt_any)
  );

  assign dack = gnt;

  dmaq_beat_seq #(.IW(IW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (gnt_any),
    .start_idx (gnt_idx),
    .start_src (src_a[gnt_idx]),
    .start_dst (dst_a[gnt_idx]),
    .start_cnt (cnt_a[gnt_idx]),
    .start_ctl (ctl_a[gnt_idx]),
    .mem_rdata (mem_rdata),
    .dev_rdata (dev_rdata),
    .busy      (busy),
    .done      (done),
    .done_idx  (done_idx),
    .wb_src    (wb_src),
    .wb_dst    (wb_dst),
    .wb_cnt    (wb_cnt),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .dev_valid (dev_valid),
    .dev_we    (dev_we),
    .dev_ch    (dev_ch),
    .dev_addr  (dev_addr),
    .dev_wdata (dev_wdata)
  );

endmodule

// File: rtl/dmaq_engine_chk.sv
module dmaq_engine_chk #(
  parameter int NUM_CH = 4,
  parameter int IW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] dack,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              dev_we,
  input logic              master_en,
  input logic [NUM_CH-1:0] te_vec,
  input logic              done,
  input logic [IW-1:0]     done_idx,
  input logic [31:0]       wb_cnt
);

  // R8
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R3
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> (master_en && ((dack & te_vec) == '0)));

  // R4
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |=> mem_valid);

  // R4
  no_grant_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (dack == '0));

  // R4
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_valid);

  // R9
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_we != dev_we));

  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wb_cnt == 32'd0) |=> te_vec[$past(done_idx)]);

endmodule

bind dmaq_engine dmaq_engine_chk #(.NUM_CH(NUM_CH), .IW(IW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .dack      (dack),
  .mem_valid (mem_valid),
  .mem_we    (mem_we),
  .dev_we    (dev_we),
  .master_en (master_en),
  .te_vec    (te_vec),
  .done      (done),
  .done_idx  (done_idx),
  .wb_cnt    (wb_cnt)
);

// File: tb/dmaq_engine_tb_top.sv
module dmaq_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic        mem_valid, mem_we, dev_valid, dev_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  dev_ch;
  logic [31:0] dev_addr, dev_wdata, dev_rdata;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  typedef struct packed {
    logic        we;
    logic [1:0]  ch;
    logic [31:0] maddr;
    logic [31:0] daddr;
    logic [31:0] data;
  } beat_t;

  beat_t exp_q[$];

  always #2 clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h0F0F_3C3C;
  endfunction

  function automatic logic [31:0] devf(input logic [31:0] a);
    return ~a + 32'h11;
  endfunction

  always_comb mem_rdata = memf(mem_addr);
  always_comb dev_rdata = devf(dev_addr);

  dmaq_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dreq(dreq), .dack(dack),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_valid(dev_valid), .dev_we(dev_we), .dev_ch(dev_ch),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  function automatic logic [6:0] ra(input int ch, input int slot);
    return 7'(ch * 16 + slot * 4);
  endfunction

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    total++;
    if (bus_rdata !== e) begin
      bad++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, bus_rdata, e);
    end
  endtask

  // driver: expected beats of one burst (R4, R9, R10)
  task automatic push_burst(input int ch, input bit to_mem, input logic [31:0] s,
                            input logic [31:0] d, input bit sinc, input bit dinc);
    for (int k = 0; k < 8; k++) begin
      beat_t b;
      logic [31:0] sb, db;
      sb = sinc ? s + 32'(4 * k) : s;
      db = dinc ? d + 32'(4 * k) : d;
      b.ch = 2'(ch);
      b.we = to_mem;
      if (!to_mem) begin
        b.maddr = sb; b.daddr = db; b.data = memf(sb);
      end else begin
        b.maddr = db; b.daddr = sb; b.data = devf(sb);
      end
      exp_q.push_back(b);
    end
  endtask

  // monitor: every beat must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && mem_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected beat actual ch=%0d maddr=%08h expected=no beat", dev_ch, mem_addr);
      end else begin
        beat_t e;
        logic [31:0] got;
        e = exp_q.pop_front();
        got = mem_we ? mem_wdata : dev_wdata;
        if (mem_we !== e.we || dev_we !== ~e.we || dev_ch !== e.ch || mem_addr !== e.maddr ||
            dev_addr !== e.daddr || got !== e.data) begin
          bad++;
          $display("FAIL R4/R9/R10 beat actual we=%0b ch=%0d m=%08h d=%08h data=%08h expected we=%0b ch=%0d m=%08h d=%08h data=%08h",
                   mem_we, dev_ch, mem_addr, dev_addr, got, e.we, e.ch, e.maddr, e.daddr, e.data);
        end
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R4 missing beats actual=%0d left expected=0", exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(ra(0, 0), 32'h0, "R1 ch0 src");
    rd_chk(ra(3, 3), 32'h0, "R1 ch3 ctl");
    rd_chk(7'h40, 32'h0, "R1 global");
    total++;
    if (dack !== 4'h0 || mem_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 outputs actual dack=%h valid=%b expected=0", dack, mem_valid);
    end

    // R2 map and readback, R3 master enable off blocks
    wr(ra(2, 3), 32'h12C0);
    wr(ra(2, 0), 32'h1000);
    wr(ra(2, 1), 32'h8000);
    wr(ra(2, 2), 32'd3);
    wr(ra(2, 3), 32'h12C1);
    dreq = 4'b0100;
    wr(7'h01, 32'hDEAD_BEEF);
    repeat (30) @(negedge clk);
    rd_chk(ra(2, 0), 32'h1000, "R2 ch2 src");
    rd_chk(ra(2, 1), 32'h8000, "R2 ch2 dst");
    rd_chk(ra(2, 3), 32'h12C1, "R2 ch2 ctl");
    rd_chk(ra(0, 0), 32'h0, "R2 unaligned write ignored");
    rd_chk(ra(2, 2), 32'd3, "R3 count held without master");

    // main memory-to-device run: three bursts
    push_burst(2, 0, 32'h1000, 32'h8000, 1, 0);
    push_burst(2, 0, 32'h1020, 32'h8000, 1, 0);
    push_burst(2, 0, 32'h1040, 32'h8000, 1, 0);
    wr(7'h40, 32'h8201);
    rd_chk(7'h40, 32'h8201, "R2 global");
    drain();
    rd_chk(ra(2, 0), 32'h1060, "R5 src advanced");
    rd_chk(ra(2, 1), 32'h8000, "R5 dst fixed");
    rd_chk(ra(2, 2), 32'h0, "R6 count zero");
    rd_chk(ra(2, 3), 32'h12C3, "R6 done flag");

    // R9 device-to-memory, incrementing destination
    wr(ra(1, 3), 32'h43C0);
    wr(ra(1, 0), 32'h0200);
    wr(ra(1, 1), 32'h4000);
    wr(ra(1, 2), 32'd2);
    push_burst(1, 1, 32'h0200, 32'h4000, 0, 1);
    push_burst(1, 1, 32'h0200, 32'h4020, 0, 1);
    dreq = 4'b0110;
    wr(ra(1, 3), 32'h43C1);
    drain();
    rd_chk(ra(1, 0), 32'h0200, "R5 d2m src fixed");
    rd_chk(ra(1, 1), 32'h4040, "R5 d2m dst advanced");
    rd_chk(ra(1, 3), 32'h43C3, "R6 d2m done flag");

    // R6 done flag blocks a reloaded count
    wr(ra(2, 2), 32'd1);
    repeat (20) @(negedge clk);
    rd_chk(ra(2, 2), 32'd1, "R6 blocked while done");

    // R7 clear done and resume
    wr(ra(2, 3), 32'h12C0);
    rd_chk(ra(2, 3), 32'h12C0, "R7 done cleared");
    push_burst(2, 0, 32'h1060, 32'h8000, 1, 0);
    wr(ra(2, 3), 32'h12C1);
    drain();
    rd_chk(ra(2, 0), 32'h1080, "R7 resumed src");
    rd_chk(ra(2, 3), 32'h12C3, "R7 done again");

    // R3 zero count enabled: no beats, no done flag
    wr(ra(1, 3), 32'h43C1);
    repeat (20) @(negedge clk);
    rd_chk(ra(1, 3), 32'h43C1, "R3 zero count idle");

    // R8 two channels raised together
    wr(ra(0, 3), 32'h12C0);
    wr(ra(0, 0), 32'h5000);
    wr(ra(0, 1), 32'hA000);
    wr(ra(0, 2), 32'd1);
    wr(ra(3, 3), 32'h12C0);
    wr(ra(3, 0), 32'h6000);
    wr(ra(3, 1), 32'hB000);
    wr(ra(3, 2), 32'd1);
    wr(ra(0, 3), 32'h12C1);
    wr(ra(3, 3), 32'h12C1);
    push_burst(0, 0, 32'h5000, 32'hA000, 1, 0);
    push_burst(3, 0, 32'h6000, 32'hB000, 1, 0);
    @(negedge clk);
    dreq = 4'b1111;
    drain();
    rd_chk(ra(0, 3), 32'h12C3, "R8 ch0 done");
    rd_chk(ra(3, 3), 32'h12C3, "R8 ch3 done");

    // R10 reserved mode keeps both sides fixed
    wr(ra(1, 3), 32'h22C0);
    wr(ra(1, 0), 32'h3000);
    wr(ra(1, 1), 32'h9000);
    wr(ra(1, 2), 32'd1);
    push_burst(1, 0, 32'h3000, 32'h9000, 0, 0);
    wr(ra(1, 3), 32'h22C1);
    drain();
    rd_chk(ra(1, 0), 32'h3000, "R10 src fixed");
    rd_chk(ra(1, 1), 32'h9000, "R10 dst fixed");
    rd_chk(ra(1, 3), 32'h22C3, "R10 done");

    finish_run();
  end

endmodule